// File: doc/BRIEF.md
# Predicated Dataflow Functional Unit

This block is a single compute tile meant to sit inside a circuit-switched dataflow fabric. It has two operand channels, A and B, and one predicate channel P. Each channel carries a data word, a validity metabit that says whether the word is meaningful, and a valid/ready handshake. A small configuration register selects the operation. The operations are add, subtract, multiply, bitwise AND, unsigned greater-than compare, and a select that merges two branch paths. The configuration also says whether the predicate is used and with which polarity.

The tile does not run on a schedule. It fires as soon as every input it needs holds a token and its output register can take a result. When it fires, it takes all of those input tokens in the same cycle. The result is kept in an output register, together with its validity metabit, until the downstream side accepts it. Branches are mapped as data. A predicated tile marks its result invalid when the branch is not taken. A select tile then passes on whichever of its two inputs is valid. A tile configured as a compare produces a one-bit result that can feed the predicate channel of later tiles.

Top module: `pdfu_tile`

## Requirements
- R1: After reset the output register is empty (`o_valid`=0). The configuration is opcode 0 (add) with the predicate disabled.
- R2: The tile fires only when all of the following hold: `a_valid` and `b_valid` are high; `p_valid` is also high if the predicate is enabled; the output register is empty or `o_ready` is high; and `cfg_load` is low. When it fires, it raises `a_ready` and `b_ready` in that cycle, and also `p_ready` if the predicate is enabled. The result appears on `o_valid`/`o_data`/`o_ok` after the next clock edge.
- R3: The opcode selects the data result. Code 0 gives A+B, 1 gives A-B, and 2 gives the low W bits of A*B, all modulo 2^W. Code 3 gives A AND B. Code 4 gives the unsigned compare A>B in bit 0, with every higher bit zero. Code 5 is select. Codes 6 to 15 behave as code 0.
- R4: For every opcode except select, the output metabit `o_ok` is the AND of `a_ok` and `b_ok`. A token is still emitted when an operand is invalid.
- R5: In select mode, if `b_ok` is 1 the output is B's word with `o_ok`=1. Otherwise, if `a_ok` is 1, the output is A's word with `o_ok`=1. If neither input is valid, the output is A's word with `o_ok`=0.
- R6: When the predicate is enabled, `o_ok` is additionally cleared unless `p_ok` is 1 and `p_bit` differs from the polarity bit. With polarity 0 the predicate is active-high; with polarity 1 it is active-low. When the predicate is disabled, `p_ready` stays 0 and the P channel has no effect on the output.
- R7: While `o_valid` is 1 and `o_ready` is 0, the output word and metabit hold steady and the tile does not fire.
- R8: On `cfg_load`, the fields `cfg_op`, `cfg_pred_en` and `cfg_pred_pol` are stored only if the output register is empty. A load presented while a result is waiting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Configuration strobe |
| cfg_op | input | 4 | Opcode to load |
| cfg_pred_en | input | 1 | Predicate enable to load |
| cfg_pred_pol | input | 1 | Predicate polarity to load (1 = active-low) |
| a_valid | input | 1 | Operand A token present |
| a_ready | output | 1 | Operand A consumed |
| a_data | input | W | Operand A word |
| a_ok | input | 1 | Operand A validity metabit |
| b_valid | input | 1 | Operand B token present |
| b_ready | output | 1 | Operand B consumed |
| b_data | input | W | Operand B word |
| b_ok | input | 1 | Operand B validity metabit |
| p_valid | input | 1 | Predicate token present |
| p_ready | output | 1 | Predicate consumed |
| p_bit | input | 1 | Predicate value |
| p_ok | input | 1 | Predicate validity metabit |
| o_valid | output | 1 | Result token present |
| o_ready | input | 1 | Downstream accepts result |
| o_data | output | W | Result word |
| o_ok | output | 1 | Result validity metabit |

## Verification
The bench sweeps every defined opcode and one undefined opcode. For each, it tries operand words at zero, one, the sign boundary and all-ones, in both orders, so that compare direction, wrap-around and truncation of the product all show up. Every combination of the two operand metabits is applied, so AND-style validity for arithmetic is told apart from select's priority of B over A. Each run is repeated with the predicate off, and with it on at both polarities with every value and metabit of the predicate, which separates polarity inversion from the invalid-predicate case. Separate sequences check three things: that a missing predicate or operand token blocks firing; that a held output freezes under backpressure; and that a configuration strobe arriving during that hold is dropped.

// File: rtl/pdfu_pkg.sv
package pdfu_pkg;
    localparam logic [3:0] OPC_ADD = 4'd0;
    localparam logic [3:0] OPC_SUB = 4'd1;
    localparam logic [3:0] OPC_MUL = 4'd2;
    localparam logic [3:0] OPC_AND = 4'd3;
    localparam logic [3:0] OPC_GT  = 4'd4;
    localparam logic [3:0] OPC_SEL = 4'd5;

    typedef struct packed {
        logic [3:0] op;
        logic       pred_en;
        logic       pred_pol;
    } cfg_t;
endpackage

// File: rtl/pdfu_cfg.sv
module pdfu_cfg
    import pdfu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);
    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (load_en) begin
            cfg_d = cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{op: OPC_ADD, pred_en: 1'b0, pred_pol: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/pdfu_alu.sv
module pdfu_alu
    import pdfu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic         a_ok,
    input  logic [W-1:0] b,
    input  logic         b_ok,
    output logic [W-1:0] res,
    output logic         res_ok
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic          gt;

    always_comb begin
        prod   = PW'(a) * PW'(b);
        gt     = a > b;
        res    = a + b;
        res_ok = a_ok & b_ok;
        case (op)
            OPC_SUB: res = a - b;
            OPC_MUL: res = prod[W-1:0];
            OPC_AND: res = a & b;
            OPC_GT:  res = {{(W-1){1'b0}}, gt};
            OPC_SEL: begin
                if (b_ok) begin
                    res    = b;
                    res_ok = 1'b1;
                end else begin
                    res    = a;
                    res_ok = a_ok;
                end
            end
            default: res = a + b;
        endcase
    end
endmodule

// File: rtl/pdfu_pred.sv
module pdfu_pred (
    input  logic pred_en,
    input  logic pred_pol,
    input  logic p_bit,
    input  logic p_ok,
    input  logic raw_ok,
    output logic gated_ok
);
    logic taken;

    always_comb begin
        taken    = p_ok & (p_bit ^ pred_pol);
        gated_ok = pred_en ? (raw_ok & taken) : raw_ok;
    end
endmodule

// File: rtl/pdfu_tile.sv
module pdfu_tile
    import pdfu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_load,
    input  logic [3:0]   cfg_op,
    input  logic         cfg_pred_en,
    input  logic         cfg_pred_pol,
    input  logic         a_valid,
    output logic         a_ready,
    input  logic [W-1:0] a_data,
    input  logic         a_ok,
    input  logic         b_valid,
    output logic         b_ready,
    input  logic [W-1:0] b_data,
    input  logic         b_ok,
    input  logic         p_valid,
    output logic         p_ready,
    input  logic         p_bit,
    input  logic         p_ok,
    output logic         o_valid,
    input  logic         o_ready,
    output logic [W-1:0] o_data,
    output logic         o_ok
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
        logic         ok;
    } out_t;

    out_t   out_d, out_q;
    cfg_t   cfg_q;
    cfg_t   cfg_new;
    logic   cfg_take;
    logic   have_all;
    logic   room;
    logic   fire;
    logic [W-1:0] alu_res;
    logic   alu_ok;
    logic   final_ok;

    assign cfg_new  = '{op: cfg_op, pred_en: cfg_pred_en, pred_pol: cfg_pred_pol};
    assign cfg_take = cfg_load & ~out_q.full;

    pdfu_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (cfg_take),
        .cfg_in  (cfg_new),
        .cfg_q   (cfg_q)
    );

    pdfu_alu #(.W(W)) u_alu (
        .op     (cfg_q.op),
        .a      (a_data),
        .a_ok   (a_ok),
        .b      (b_data),
        .b_ok   (b_ok),
        .res    (alu_res),
        .res_ok (alu_ok)
    );

    pdfu_pred u_pred (
        .pred_en  (cfg_q.pred_en),
        .pred_pol (cfg_q.pred_pol),
        .p_bit    (p_bit),
        .p_ok     (p_ok),
        .raw_ok   (alu_ok),
        .gated_ok (final_ok)
    );

    always_comb begin
        have_all = a_valid & b_valid & (p_valid | ~cfg_q.pred_en);
        room     = ~out_q.full | o_ready;
        fire     = have_all & room & ~cfg_load;
        out_d    = out_q;
        if (fire) begin
            out_d.full = 1'b1;
            out_d.data = alu_res;
            out_d.ok   = final_ok;
        end else if (o_ready) begin
            out_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign a_ready = fire;
    assign b_ready = fire;
    assign p_ready = fire & cfg_q.pred_en;
    assign o_valid = out_q.full;
    assign o_data  = out_q.data;
    assign o_ok    = out_q.ok;
endmodule

// File: rtl/pdfu_tile_chk.sv
module pdfu_tile_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_load,
    input logic         a_valid,
    input logic         a_ready,
    input logic         b_valid,
    input logic         b_ready,
    input logic         p_valid,
    input logic         p_ready,
    input logic         o_valid,
    input logic         o_ready,
    input logic [W-1:0] o_data,
    input logic         o_ok
);
    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_ok)));

    // R7
    no_fire_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |-> !a_ready);

    // R2
    joint_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready |-> (b_ready && a_valid && b_valid));

    // R2
    emit_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready |=> o_valid);

    // R6
    pred_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_ready |-> (a_ready && p_valid));

    // R8
    cfg_blocks_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> !a_ready);
endmodule

bind pdfu_tile pdfu_tile_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .a_valid  (a_valid),
    .a_ready  (a_ready),
    .b_valid  (b_valid),
    .b_ready  (b_ready),
    .p_valid  (p_valid),
    .p_ready  (p_ready),
    .o_valid  (o_valid),
    .o_ready  (o_ready),
    .o_data   (o_data),
    .o_ok     (o_ok)
);

// File: tb/pdfu_tile_test.sv
module pdfu_tile_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cfg_load;
    logic [3:0]   cfg_op;
    logic         cfg_pred_en;
    logic         cfg_pred_pol;
    logic         a_valid, a_ready, a_ok;
    logic [W-1:0] a_data;
    logic         b_valid, b_ready, b_ok;
    logic [W-1:0] b_data;
    logic         p_valid, p_ready, p_bit, p_ok;
    logic         o_valid, o_ready, o_ok;
    logic [W-1:0] o_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic       cur_pen;
    logic       cur_pol;
    logic [3:0] cur_op;

    always #2 clk = ~clk;

    pdfu_tile #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_load(cfg_load), .cfg_op(cfg_op),
        .cfg_pred_en(cfg_pred_en), .cfg_pred_pol(cfg_pred_pol),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_ok(a_ok),
        .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data), .b_ok(b_ok),
        .p_valid(p_valid), .p_ready(p_ready), .p_bit(p_bit), .p_ok(p_ok),
        .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_ok(o_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W:0] model(input logic [3:0] op, input logic pen, input logic pol,
                                         input logic [W-1:0] a, input logic aok,
                                         input logic [W-1:0] b, input logic bok,
                                         input logic pb, input logic pok);
        logic [W-1:0] r;
        logic         ok;
        logic [2*W-1:0] pr;
        pr = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        ok = aok & bok;
        case (op)
            4'd1: r = a - b;
            4'd2: r = pr[W-1:0];
            4'd3: r = a & b;
            4'd4: r = (a > b) ? 1 : 0;
            4'd5: begin
                r  = bok ? b : a;
                ok = aok | bok;
            end
            default: r = a + b;
        endcase
        if (pen && !(pok && (pb != pol))) ok = 1'b0;
        return {ok, r};
    endfunction

    task automatic load_cfg(input logic [3:0] op, input logic pen, input logic pol);
        @(negedge clk);
        cfg_load = 1'b1; cfg_op = op; cfg_pred_en = pen; cfg_pred_pol = pol;
        @(negedge clk);
        cfg_load = 1'b0;
        cur_op = op; cur_pen = pen; cur_pol = pol;
    endtask

    task automatic tok(input string req, input logic [W-1:0] a, input logic aok,
                       input logic [W-1:0] b, input logic bok,
                       input logic pb, input logic pok);
        logic [W:0] e;
        e = model(cur_op, cur_pen, cur_pol, a, aok, b, bok, pb, pok);
        a_valid = 1'b1; a_data = a; a_ok = aok;
        b_valid = 1'b1; b_data = b; b_ok = bok;
        p_valid = cur_pen; p_bit = pb; p_ok = pok;
        #1;
        chk({req, " R2 fire"}, {31'd0, a_ready}, 32'd1);
        chk({req, " R6 pready"}, {31'd0, p_ready}, {31'd0, cur_pen});
        @(negedge clk);
        a_valid = 1'b0; b_valid = 1'b0; p_valid = 1'b0;
        chk({req, " R2 ovalid"}, {31'd0, o_valid}, 32'd1);
        chk({req, " data"}, {24'd0, o_data}, {24'd0, e[W-1:0]});
        chk({req, " ok"}, {31'd0, o_ok}, {31'd0, e[W]});
    endtask

    initial begin
        #600000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] vals [4];
        logic [W:0] e;
        vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h80; vals[3] = 8'hFF;
        rst_n = 1'b0; cfg_load = 1'b0; cfg_op = 4'd0; cfg_pred_en = 1'b0; cfg_pred_pol = 1'b0;
        a_valid = 1'b0; a_data = '0; a_ok = 1'b0;
        b_valid = 1'b0; b_data = '0; b_ok = 1'b0;
        p_valid = 1'b0; p_bit = 1'b0; p_ok = 1'b0; o_ready = 1'b1;
        cur_op = 4'd0; cur_pen = 1'b0; cur_pol = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty after reset", {31'd0, o_valid}, 32'd0);
        tok("R1 default add", 8'd3, 1'b1, 8'd4, 1'b1, 1'b0, 1'b0);

        // R3 R4 R5 R6 sweep
        for (int op = 0; op < 7; op++) begin
            for (int pc = 0; pc < 9; pc++) begin
                logic pen, pol, pb, pok;
                logic [3:0] opv;
                opv = (op == 6) ? 4'd9 : 4'(op);
                pen = (pc != 0);
                pol = (pc > 4);
                pb  = pen ? (((pc - 1) % 4) >= 2) : 1'b1;
                pok = pen ? (((pc - 1) % 2) == 1) : 1'b0;
                load_cfg(opv, pen, pol);
                for (int ia = 0; ia < 4; ia++) begin
                    for (int ib = 0; ib < 4; ib++) begin
                        for (int k = 0; k < 4; k++) begin
                            tok("R3 R4 R5 R6 sweep", vals[ia], k[0], vals[ib], k[1], pb, pok);
                        end
                    end
                end
            end
        end

        // R2 missing operand or predicate blocks firing
        load_cfg(4'd0, 1'b1, 1'b0);
        @(negedge clk);
        a_valid = 1'b1; b_valid = 1'b1; p_valid = 1'b0; a_data = 8'd5; b_data = 8'd6;
        #1;
        chk("R2 no fire without predicate", {31'd0, a_ready}, 32'd0);
        @(negedge clk);
        chk("R2 no output without predicate", {31'd0, o_valid}, 32'd0);
        a_valid = 1'b0; b_valid = 1'b0;
        load_cfg(4'd0, 1'b0, 1'b0);
        @(negedge clk);
        a_valid = 1'b1;
        #1;
        chk("R2 no fire with only A", {31'd0, a_ready}, 32'd0);
        @(negedge clk);
        chk("R2 no output with only A", {31'd0, o_valid}, 32'd0);
        a_valid = 1'b0;

        // R7 backpressure hold and R8 ignored load
        @(negedge clk);
        o_ready = 1'b0;
        a_valid = 1'b1; a_data = 8'd10; a_ok = 1'b1;
        b_valid = 1'b1; b_data = 8'd20; b_ok = 1'b1;
        @(negedge clk);
        chk("R7 first token held", {24'd0, o_data}, 32'd30);
        a_data = 8'd50; b_data = 8'd7;
        #1;
        chk("R7 no fire while held", {31'd0, a_ready}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R7 data stable", {24'd0, o_data}, 32'd30);
        chk("R7 valid stable", {31'd0, o_valid}, 32'd1);
        cfg_load = 1'b1; cfg_op = 4'd1;
        @(negedge clk);
        cfg_load = 1'b0;
        o_ready = 1'b1;
        @(negedge clk);
        a_valid = 1'b0; b_valid = 1'b0;
        chk("R8 load ignored while held", {24'd0, o_data}, 32'd57);
        @(negedge clk);
        chk("R7 drains on ready", {31'd0, o_valid}, 32'd0);

        // R8 load accepted when idle
        cur_op = 4'd0;
        load_cfg(4'd1, 1'b0, 1'b0);
        tok("R8 load taken when idle", 8'd50, 1'b1, 8'd7, 1'b1, 1'b0, 1'b0);
        e = model(4'd1, 1'b0, 1'b0, 8'd50, 1'b1, 8'd7, 1'b1, 1'b0, 1'b0);
        chk("R8 model sub", {23'd0, e}, {23'd0, 9'h12B});

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule